// File: doc/BRIEF.md
# TLB Maintenance Register Interface

This block gives software a window onto a set-associative translation buffer through three registers. The first is a page-table address register, which holds the virtual page number used as an index. The second is an entry-access register, which carries the permission flags and the physical frame number. The third is a control register, which holds the current process identifier, the way selector and the read and write command bits. Writes to these registers have side effects. Writing the access register while write-enable is set commits a whole entry into storage and steps the way selector. Writing the control register with its read bit set pulls an entry back into all three registers. Changing the process identifier starts a scan that asks for every page owned by the old identifier to be flushed.

Each register keeps its read-back value apart from the value last written to it. A write to the access register, or to the page-number field of the address register, therefore leaves the read-back value unchanged. Only a read command loads those values. Entries are indexed by the way and by the low bits of the page number. The flush requests are single-cycle pulses that the surrounding translation cache consumes. While a scan runs, the block ignores register writes.

Top module: `tlb_maint_regs`

## Requirements
- R1: After reset the three read-back values are zero, `busy` is low and neither flush pulse is high.
- R2: A write to the access register (sel 1) while control bit 1 (write-enable) is set stores an entry at index way*SETS + (page number mod SETS). The way comes from control bits 28 and up. The page number is the one last written to address-register bits 21:2. The process identifier is the one last written to control bits 4 and up. The global flag comes from data bit 24.
- R3: A committed entry is valid only when its page number is below 0xC0000. An invalid entry never causes a flush.
- R4: A committed entry keeps only data bits 23:0 (C=23, R=22, W=21, X=20, frame number 19:0) plus the global flag from bit 24. Data bits 31:25 are dropped.
- R5: After each committed entry, the control way field becomes (way+1) mod WAYS. An access write with write-enable clear stores nothing and leaves the way unchanged.
- R6: A write to the access register never changes the access read-back. A write to the address register (sel 0) updates read-back bits 31:22 and 1:0 but leaves the page-number field 21:2 unchanged.
- R7: A control write (sel 2) with bit 0 set reads the entry at way (from the written value) and page number (the last written one). The access read-back becomes {bits 31:25 kept, global, C, R, W, X, frame}. The control read-back becomes the written value with its identifier field replaced by the entry's identifier. The address read-back page-number field becomes the entry's page number.
- R8: A control write whose identifier differs from the last written identifier pulses `pid_flush_vld` with the old identifier in the next cycle. It then raises `busy` and, for entry index i, pulses `page_flush_vld` in the (i+2)th cycle after the write whenever that entry is valid, not global and owned by the old identifier. `busy` falls after all entries have been visited.
- R9: Register writes presented while `busy` is high are ignored.
- R10: A commit over a valid entry whose content changes pulses `page_flush_vld` with the old page number in the next cycle. Rewriting identical content, or overwriting an invalid entry, gives no pulse.
- R11: A control write with bit 0 clear is read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Single-cycle register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 access, 2 control, 3 none |
| reg_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Access register read-back |
| misc_rdata | output | 32 | Control register read-back |
| pte_rdata | output | 32 | Address register read-back |
| busy | output | 1 | Identifier flush scan running; writes ignored |
| pid_flush_vld | output | 1 | Flush-by-identifier pulse |
| pid_flush_id | output | PID_W | Identifier being flushed |
| page_flush_vld | output | 1 | Flush-one-page pulse |
| page_flush_vpn | output | 20 | Page number to flush |

## Verification
All sixteen entries are filled through the normal commit path, with distinct page numbers, frames and flag patterns. Two identifiers are used, some entries are global and one page number lies in the invalid range. All sixteen are then read back through the read command. This separates index errors, field-packing errors and identifier-capture errors. Identifier changes are checked cycle by cycle against the expected flush pattern for each index, which tells the valid, global and owner filters apart. Overwrites with changed content, identical content and invalid content distinguish the page-flush condition. Writes issued during a scan, and commits with write-enable clear, show that ignored writes leave every read-back unchanged.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  localparam int VPN_W = 20;
  localparam int PFN_W = 20;
  localparam int DATA_W = PFN_W + 4;
  // access register layout
  localparam int ACC_G_BIT = 24;
  localparam int ACC_KEEP_LO = 25;
  // control register layout
  localparam int MISC_RD_BIT = 0;
  localparam int MISC_WE_BIT = 1;
  localparam int MISC_PID_LO = 4;
  localparam int MISC_WAY_LO = 28;
  // address register layout
  localparam int PTE_VPN_LO = 2;
  localparam int PTE_BASE_LO = PTE_VPN_LO + VPN_W;
  localparam logic [VPN_W-1:0] VPN_VALID_LIMIT = 20'hC0000;

  typedef enum logic [1:0] {
    SEL_PTE  = 2'd0,
    SEL_ACC  = 2'd1,
    SEL_MISC = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             c;
    logic             r;
    logic             w;
    logic             x;
    logic [PFN_W-1:0] pfn;
  } tlb_data_t;
endpackage

// File: rtl/tlbm_store.sv
module tlbm_store
  import tlbm_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int SETS  = 8,
  parameter int PID_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(WAYS*SETS)-1:0] widx,
  input  logic [VPN_W-1:0]         wvpn,
  input  logic                     wg,
  input  logic                     wv,
  input  logic [PID_W-1:0]         wpid,
  input  tlb_data_t                wdat,
  input  logic [$clog2(WAYS*SETS)-1:0] ridx,
  output logic [VPN_W-1:0]         rvpn,
  output logic                     rg,
  output logic                     rv,
  output logic [PID_W-1:0]         rpid,
  output tlb_data_t                rdat,
  input  logic [$clog2(WAYS*SETS)-1:0] sidx,
  output logic [VPN_W-1:0]         svpn,
  output logic                     sg,
  output logic                     sv,
  output logic [PID_W-1:0]         spid
);
  localparam int ENTRIES = WAYS * SETS;

  logic [VPN_W-1:0] vpn_q [ENTRIES];
  logic             g_q   [ENTRIES];
  logic             v_q   [ENTRIES];
  logic [PID_W-1:0] pid_q [ENTRIES];
  tlb_data_t        dat_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i] <= '0;
        g_q[i]   <= 1'b0;
        v_q[i]   <= 1'b0;
        pid_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (we) begin
      vpn_q[widx] <= wvpn;
      g_q[widx]   <= wg;
      v_q[widx]   <= wv;
      pid_q[widx] <= wpid;
      dat_q[widx] <= wdat;
    end
  end

  assign rvpn = vpn_q[ridx];
  assign rg   = g_q[ridx];
  assign rv   = v_q[ridx];
  assign rpid = pid_q[ridx];
  assign rdat = dat_q[ridx];

  assign svpn = vpn_q[sidx];
  assign sg   = g_q[sidx];
  assign sv   = v_q[sidx];
  assign spid = pid_q[sidx];

  // R3
  valid_rule_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (v_q[$past(widx)] == ($past(wvpn) < VPN_VALID_LIMIT)));
endmodule

// File: rtl/tlbm_scan.sv
module tlbm_scan
  import tlbm_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PID_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [PID_W-1:0]           start_pid,
  output logic [$clog2(ENTRIES)-1:0] sidx,
  input  logic [VPN_W-1:0]           svpn,
  input  logic                       sg,
  input  logic                       sv,
  input  logic [PID_W-1:0]           spid,
  output logic                       busy,
  output logic                       pid_vld,
  output logic [PID_W-1:0]           pid_out,
  output logic                       pg_vld,
  output logic [VPN_W-1:0]           pg_vpn
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] idx_q;
  logic [PID_W-1:0] pid_q;
  logic             hit;

  assign sidx = idx_q;
  assign hit  = busy && sv && !sg && (spid == pid_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      idx_q   <= '0;
      pid_q   <= '0;
      pid_vld <= 1'b0;
      pid_out <= '0;
      pg_vld  <= 1'b0;
      pg_vpn  <= '0;
    end else begin
      pid_vld <= start && !busy;
      pg_vld  <= hit;
      pg_vpn  <= svpn;
      if (start && !busy) begin
        busy    <= 1'b1;
        idx_q   <= '0;
        pid_q   <= start_pid;
        pid_out <= start_pid;
      end else if (busy) begin
        if (idx_q == LAST) busy <= 1'b0;
        else idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && pid_vld && idx_q == '0));
  // R8
  scan_end_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && idx_q == LAST) |=> !busy);
  // R8
  pg_in_scan_chk: assert property (@(posedge clk) disable iff (rst)
    pg_vld |-> $past(busy));
endmodule

// File: rtl/tlbm_regs.sv
module tlbm_regs
  import tlbm_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int SETS  = 8,
  parameter int PID_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [1:0]               sel,
  input  logic [31:0]              wdata,
  output logic [31:0]              acc_rb,
  output logic [31:0]              misc_rb,
  output logic [31:0]              pte_rb,
  output logic [$clog2(WAYS*SETS)-1:0] ridx,
  input  logic [VPN_W-1:0]         rvpn,
  input  logic                     rg,
  input  logic                     rv,
  input  logic [PID_W-1:0]         rpid,
  input  tlb_data_t                rdat,
  output logic                     st_we,
  output logic [VPN_W-1:0]         st_vpn,
  output logic                     st_g,
  output logic                     st_v,
  output logic [PID_W-1:0]         st_pid,
  output tlb_data_t                st_dat,
  output logic                     pid_chg,
  output logic [PID_W-1:0]         old_pid,
  output logic                     cflush_vld,
  output logic [VPN_W-1:0]         cflush_vpn
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int SET_W = $clog2(SETS);

  reg_sel_e         sel_e;
  logic             is_acc, is_misc, is_pte, commit, changed;
  logic [WAY_W-1:0] misc_way, wr_way;
  logic [PID_W-1:0] pid_last, wr_pid;
  logic [VPN_W-1:0] vpn_last;
  logic [31:0]      misc_rd_val;

  assign sel_e    = reg_sel_e'(sel);
  assign is_acc   = wr_en && (sel_e == SEL_ACC);
  assign is_misc  = wr_en && (sel_e == SEL_MISC);
  assign is_pte   = wr_en && (sel_e == SEL_PTE);
  assign misc_way = misc_rb[MISC_WAY_LO +: WAY_W];
  assign wr_way   = wdata[MISC_WAY_LO +: WAY_W];
  assign wr_pid   = wdata[MISC_PID_LO +: PID_W];
  assign commit   = is_acc && misc_rb[MISC_WE_BIT];

  assign ridx = is_misc ? {wr_way, vpn_last[SET_W-1:0]}
                        : {misc_way, vpn_last[SET_W-1:0]};

  assign st_we  = commit;
  assign st_vpn = vpn_last;
  assign st_g   = wdata[ACC_G_BIT];
  assign st_v   = vpn_last < VPN_VALID_LIMIT;
  assign st_pid = pid_last;
  assign st_dat = tlb_data_t'(wdata[DATA_W-1:0]);

  assign changed = (rvpn != st_vpn) || (rg != st_g) || (rv != st_v) ||
                   (rpid != st_pid) || (rdat != st_dat);

  assign pid_chg = is_misc && (wr_pid != pid_last);
  assign old_pid = pid_last;

  always_comb begin
    misc_rd_val = wdata;
    misc_rd_val[MISC_PID_LO +: PID_W] = rpid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rb     <= '0;
      misc_rb    <= '0;
      pte_rb     <= '0;
      pid_last   <= '0;
      vpn_last   <= '0;
      cflush_vld <= 1'b0;
      cflush_vpn <= '0;
    end else begin
      cflush_vld <= commit && rv && changed;
      cflush_vpn <= rvpn;
      if (commit) begin
        misc_rb[MISC_WAY_LO +: WAY_W] <= misc_way + 1'b1;
      end
      if (is_misc) begin
        pid_last <= wr_pid;
        if (wdata[MISC_RD_BIT]) begin
          acc_rb  <= {acc_rb[31:ACC_KEEP_LO], rg, rdat};
          misc_rb <= misc_rd_val;
          pte_rb[PTE_VPN_LO +: VPN_W] <= rvpn;
        end else begin
          misc_rb <= wdata;
        end
      end
      if (is_pte) begin
        pte_rb   <= {wdata[31:PTE_BASE_LO], pte_rb[PTE_BASE_LO-1:PTE_VPN_LO],
                     wdata[PTE_VPN_LO-1:0]};
        vpn_last <= wdata[PTE_VPN_LO +: VPN_W];
      end
    end
  end

  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    is_acc |=> $stable(acc_rb));
  // R6
  pte_vpn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    is_pte |=> $stable(pte_rb[PTE_VPN_LO +: VPN_W]));
  // R5
  way_step_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (misc_rb[MISC_WAY_LO +: WAY_W] == WAY_W'($past(misc_way) + 1'b1)));
  // R5
  way_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (is_acc && !commit) |=> $stable(misc_rb));
  // R10
  flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
    cflush_vld |-> $past(commit));
endmodule

// File: rtl/tlb_maint_regs.sv
module tlb_maint_regs
  import tlbm_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int SETS  = 8,
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      acc_rdata,
  output logic [31:0]      misc_rdata,
  output logic [31:0]      pte_rdata,
  output logic             busy,
  output logic             pid_flush_vld,
  output logic [PID_W-1:0] pid_flush_id,
  output logic             page_flush_vld,
  output logic [VPN_W-1:0] page_flush_vpn
);
  localparam int ENTRIES = WAYS * SETS;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic             wr_en;
  logic [IDX_W-1:0] ridx, sidx;
  logic [VPN_W-1:0] rvpn, svpn, st_vpn, c_vpn, s_vpn;
  logic             rg, rv, sg, sv, st_we, st_g, st_v;
  logic [PID_W-1:0] rpid, spid, st_pid, old_pid;
  tlb_data_t        rdat, st_dat;
  logic             pid_chg, c_vld, s_vld;

  assign wr_en = reg_we && !busy;

  tlbm_regs #(.WAYS(WAYS), .SETS(SETS), .PID_W(PID_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(reg_sel), .wdata(reg_wdata),
    .acc_rb(acc_rdata), .misc_rb(misc_rdata), .pte_rb(pte_rdata),
    .ridx(ridx), .rvpn(rvpn), .rg(rg), .rv(rv), .rpid(rpid), .rdat(rdat),
    .st_we(st_we), .st_vpn(st_vpn), .st_g(st_g), .st_v(st_v),
    .st_pid(st_pid), .st_dat(st_dat),
    .pid_chg(pid_chg), .old_pid(old_pid),
    .cflush_vld(c_vld), .cflush_vpn(c_vpn)
  );

  tlbm_store #(.WAYS(WAYS), .SETS(SETS), .PID_W(PID_W)) u_store (
    .clk(clk), .rst(rst), .we(st_we), .widx(ridx),
    .wvpn(st_vpn), .wg(st_g), .wv(st_v), .wpid(st_pid), .wdat(st_dat),
    .ridx(ridx), .rvpn(rvpn), .rg(rg), .rv(rv), .rpid(rpid), .rdat(rdat),
    .sidx(sidx), .svpn(svpn), .sg(sg), .sv(sv), .spid(spid)
  );

  tlbm_scan #(.ENTRIES(ENTRIES), .PID_W(PID_W)) u_scan (
    .clk(clk), .rst(rst), .start(pid_chg), .start_pid(old_pid),
    .sidx(sidx), .svpn(svpn), .sg(sg), .sv(sv), .spid(spid),
    .busy(busy), .pid_vld(pid_flush_vld), .pid_out(pid_flush_id),
    .pg_vld(s_vld), .pg_vpn(s_vpn)
  );

  assign page_flush_vld = c_vld || s_vld;
  assign page_flush_vpn = c_vld ? c_vpn : s_vpn;

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(acc_rdata) && $stable(misc_rdata) && $stable(pte_rdata)));
  // R10
  one_flush_src_chk: assert property (@(posedge clk) disable iff (rst)
    !(c_vld && s_vld));
endmodule

// File: tb/tlb_maint_regs_bench.sv
module tlb_maint_regs_bench;
  localparam int CLK_P = 10;
  localparam int WAYS  = 2;
  localparam int SETS  = 8;
  localparam int PID_W = 8;
  localparam int E     = WAYS * SETS;

  logic clk = 1'b0, rst = 1'b1, reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic [31:0] reg_wdata = '0;
  logic [31:0] acc_rdata, misc_rdata, pte_rdata;
  logic busy, pid_flush_vld, page_flush_vld;
  logic [PID_W-1:0] pid_flush_id;
  logic [19:0] page_flush_vpn;

  int tests = 0, fails = 0;

  logic [19:0] m_vpn [E];
  logic        m_g   [E];
  logic        m_v   [E];
  logic [7:0]  m_pid [E];
  logic [23:0] m_dat [E];
  int          e_way;
  logic [7:0]  e_pid;
  logic [19:0] rb_vpn;
  logic [31:0] e_acc;

  always #(CLK_P/2) clk = ~clk;

  tlb_maint_regs #(.WAYS(WAYS), .SETS(SETS), .PID_W(PID_W)) u_tlb_maint_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .acc_rdata(acc_rdata), .misc_rdata(misc_rdata), .pte_rdata(pte_rdata),
    .busy(busy), .pid_flush_vld(pid_flush_vld), .pid_flush_id(pid_flush_id),
    .page_flush_vld(page_flush_vld), .page_flush_vpn(page_flush_vpn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 2'd3;
  endtask

  function automatic logic [31:0] mk_misc(int way, logic [7:0] pid, bit we, bit rd);
    return (32'(way) << 28) | (32'(pid) << 4) | 32'h4 | (32'(we) << 1) | 32'(rd);
  endfunction

  function automatic logic [31:0] mk_pte(logic [19:0] vpn);
    return {10'h155, vpn, 2'b01};
  endfunction

  function automatic logic [19:0] vpn_of(int w, int s);
    if (w == 1 && s == 7) return 20'hC0007;
    return 20'(((w * SETS + s + 1) << 3) | s);
  endfunction

  function automatic logic [31:0] acc_of(int w, int s);
    logic [31:0] r;
    r = 32'hFE00_0000;
    r[24]    = (s == 3);
    r[23:20] = 4'(w * 5 + s);
    r[19:0]  = 20'hA0000 + 20'(w * SETS + s);
    return r;
  endfunction

  // R2 R4 R5 R6 R10: commit one entry through the normal path
  task automatic commit(input logic [19:0] vpn, input logic [31:0] a);
    int idx;
    bit exp_fl, nv;
    logic [19:0] ovpn;
    wr(2'd0, mk_pte(vpn));
    chk("R6 pte vpn field held", pte_rdata, {10'h155, rb_vpn, 2'b01});
    idx = e_way * SETS + int'(vpn % SETS);
    nv = (vpn < 20'hC0000);
    exp_fl = m_v[idx] && (m_vpn[idx] != vpn || m_g[idx] != a[24] || m_v[idx] != nv ||
                          m_pid[idx] != e_pid || m_dat[idx] != a[23:0]);
    ovpn = m_vpn[idx];
    wr(2'd1, a);
    chk("R10 page flush on commit", 32'(page_flush_vld), 32'(exp_fl));
    if (exp_fl) chk("R10 flushed page", 32'(page_flush_vpn), 32'(ovpn));
    chk("R6 access read-back held", acc_rdata, e_acc);
    e_way = (e_way + 1) % WAYS;
    chk("R5 way step", 32'(misc_rdata[31:28]), 32'(e_way));
    m_vpn[idx] = vpn; m_g[idx] = a[24]; m_v[idx] = nv;
    m_pid[idx] = e_pid; m_dat[idx] = a[23:0];
  endtask

  // R2 R4 R7: read one entry back into the registers
  task automatic rd_check(input int w, input int s);
    int idx;
    wr(2'd0, mk_pte(20'(s)));
    chk("R6 pte vpn field held", pte_rdata, {10'h155, rb_vpn, 2'b01});
    wr(2'd2, mk_misc(w, e_pid, 1'b0, 1'b1));
    idx = w * SETS + s;
    e_acc = {7'h0, m_g[idx], m_dat[idx]};
    chk("R7 R4 access read", acc_rdata, e_acc);
    chk("R7 R2 control read", misc_rdata, mk_misc(w, m_pid[idx], 1'b0, 1'b1));
    chk("R7 R2 address read", pte_rdata, {10'h155, m_vpn[idx], 2'b01});
    rb_vpn = m_vpn[idx];
  endtask

  // R8 R3: pid flush scan, pulse for index i in cycle i+2 after the write
  task automatic pid_change(input logic [7:0] newpid, input int way);
    logic [7:0] oldp;
    bit m;
    oldp = e_pid;
    wr(2'd2, mk_misc(way, newpid, 1'b1, 1'b0));
    e_pid = newpid; e_way = way;
    chk("R11 control write", misc_rdata, mk_misc(way, newpid, 1'b1, 1'b0));
    chk("R8 pid flush pulse", 32'(pid_flush_vld), 32'd1);
    chk("R8 pid flush id", 32'(pid_flush_id), 32'(oldp));
    chk("R8 busy", 32'(busy), 32'd1);
    for (int i = 0; i < E; i++) begin
      @(negedge clk);
      m = m_v[i] && !m_g[i] && (m_pid[i] == oldp);
      chk("R8 R3 scan flush", 32'(page_flush_vld), 32'(m));
      if (m) chk("R8 scan vpn", 32'(page_flush_vpn), 32'(m_vpn[i]));
    end
    chk("R8 busy end", 32'(busy), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < E; i++) begin
      m_vpn[i] = '0; m_g[i] = 0; m_v[i] = 0; m_pid[i] = '0; m_dat[i] = '0;
    end
    e_way = 0; e_pid = 8'h00; rb_vpn = '0; e_acc = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 acc", acc_rdata, 32'h0);
    chk("R1 misc", misc_rdata, 32'h0);
    chk("R1 pte", pte_rdata, 32'h0);
    chk("R1 busy", 32'(busy), 32'h0);
    chk("R1 flushes", 32'({pid_flush_vld, page_flush_vld}), 32'h0);

    pid_change(8'h05, 0);
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < WAYS; w++) commit(vpn_of(w, s), acc_of(w, s));
    pid_change(8'h09, 0);
    for (int s = 4; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) commit(vpn_of(w, s), acc_of(w, s));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) rd_check(w, s);

    // R3: entry 15 is invalid, so no flush for it
    pid_change(8'h03, 0);
    // R10: changed content, identical rewrite, invalid overwrite
    commit(vpn_of(0, 0), acc_of(0, 0));
    wr(2'd2, mk_misc(0, 8'h03, 1'b1, 1'b0)); e_way = 0;
    commit(vpn_of(0, 0), acc_of(0, 0));
    commit(vpn_of(1, 7), acc_of(1, 6));

    // R9: writes during a scan are ignored
    wr(2'd2, mk_misc(0, 8'h04, 1'b1, 1'b0)); e_pid = 8'h04; e_way = 0;
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd2, 32'h1234_5670);
    chk("R9 busy during writes", 32'(busy), 32'd1);
    for (int k = 0; k < 4 * E && busy; k++) @(negedge clk);
    chk("R9 pte unchanged", pte_rdata, {10'h155, rb_vpn, 2'b01});
    chk("R9 misc unchanged", misc_rdata, mk_misc(0, 8'h04, 1'b1, 1'b0));

    // R5: write-enable clear, no store and no step
    wr(2'd2, mk_misc(1, 8'h04, 1'b0, 1'b0));
    wr(2'd1, 32'h00FF_FFFF);
    chk("R5 way kept", misc_rdata, mk_misc(1, 8'h04, 1'b0, 1'b0));
    chk("R5 no flush", 32'(page_flush_vld), 32'd0);
    wr(2'd2, mk_misc(1, 8'h04, 1'b0, 1'b1));
    chk("R5 entry unchanged", acc_rdata, {7'h0, m_g[15], m_dat[15]});

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule